// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads a two-level translation table held in memory, one level at a time. A requester hands over the virtual address with two qualifiers: whether the access is a write, and whether it comes from user mode. The walker splits the address into three fields:

- a directory index (bits 31:22),
- a table index (bits 21:12),
- a page offset (bits 11:0).

It first reads a directory word. The directory page is named by a root page-number input. If that entry is usable, it reads a table word from the page the entry names. It then answers with either a physical address or a fault.

Each entry is 32 bits wide. The upper 20 bits hold a page number. Flags sit in the low bits: bit 0 means present, bit 1 means writable and bit 2 means user-accessible. Access is granted only when both levels allow it. Writes need the writable bit even in supervisor mode. So a mapping with only the present bit set is read-only to the kernel and unreachable from user mode. Software that wants different kernel and user rights on one physical page maps that page twice.

Memory is reached through a request channel with valid/ready and a response channel that may take any number of cycles. Only one walk is in flight at a time.

Top module: `pagewalk_unit`

## Requirements
- R1: The first memory read of a walk goes to address {root_ppn, va[31:22], 2'b00}.
- R2: When the directory entry allows the access, the second read goes to address {directory_entry[31:12], va[21:12], 2'b00}.
- R3: A walk whose two entries both allow the access reports res_fault=0, res_cause=0 and res_paddr = {table_entry[31:12], va[11:0]}.
- R4: A directory entry with bit 0 (present) clear ends the walk after one read, with res_fault=1, res_cause=1 (absent) and res_level=0 (directory).
- R5: A table entry with bit 0 clear gives res_fault=1, res_cause=1 and res_level=1 (table).
- R6: A user access (req_user=1) is refused with res_cause=3 unless bit 2 is set in both entries. res_level names the first entry that lacks the bit, and a refusal at directory level issues no table read.
- R7: A write (req_write=1), from either privilege level, is refused with res_cause=2 unless bit 1 is set in both entries. res_level names the first entry that lacks the bit.
- R8: The directory entry is judged before the table entry. Within one entry, an absent entry outranks a user refusal, and a user refusal outranks a write refusal.
- R9: req_ready drops in the cycle after a request is taken and stays low until the result. res_valid is high for exactly one cycle per walk.
- R10: A memory request stays asserted with a stable address until mem_req_ready. Responses are taken after any number of wait cycles.
- R11: Entry bits 11:3 have no effect on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| root_ppn | input | 20 | Page number of the directory page |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| mem_req_valid | output | 1 | Word read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry word returned |
| res_valid | output | 1 | One-cycle result strobe |
| res_paddr | output | 32 | Physical address (zero on a fault) |
| res_fault | output | 1 | Translation refused |
| res_cause | output | 2 | 0 none, 1 absent, 2 write refused, 3 user refused |
| res_level | output | 1 | 0 directory, 1 table |

## Verification
A corrupted sequencer state shows up at the memory port first. A table read goes missing or an extra one appears after a directory refusal, so the read count and the captured addresses expose it within the same walk. A wrong latched address, privilege or page number appears in the physical address or cause strobed at the end of that walk. The bench sweeps every present/writable/user pairing of both levels against all four access kinds. Junk sits in the unused flag bits throughout, and memory stalls vary from cycle to cycle. Aliased pages with different rights confirm that each walk is judged only by its own entries.

// File: rtl/pgw_pkg.sv
// Package: shared flag positions, fault cause codes and walker states.
package pgw_pkg;
    localparam int FLAG_PRESENT = 0;
    localparam int FLAG_WRITE   = 1;
    localparam int FLAG_USER    = 2;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_ABSENT = 2'd1,
        CAUSE_WRITE  = 2'd2,
        CAUSE_USER   = 2'd3
    } cause_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_REQ,
        ST_DIR_WAIT,
        ST_TBL_REQ,
        ST_TBL_WAIT
    } walk_st_e;
endpackage

// File: rtl/pgw_entry_check.sv
// Judges one translation entry against one access.
// Assumes: flag positions from pgw_pkg; bits other than those three are ignored.
// Priority inside an entry: absent, then user refusal, then write refusal.
module pgw_entry_check
    import pgw_pkg::*;
#(
    parameter int ENTRY_W = 32
) (
    input  logic [ENTRY_W-1:0] entry,
    input  logic               is_write,
    input  logic               is_user,
    output logic               deny,
    output logic [1:0]         cause
);
    // Pick the highest-ranked reason this entry refuses the access.
    always_comb begin
        cause = CAUSE_NONE;
        if (!entry[FLAG_PRESENT])
            cause = CAUSE_ABSENT;
        else if (is_user && !entry[FLAG_USER])
            cause = CAUSE_USER;
        else if (is_write && !entry[FLAG_WRITE])
            cause = CAUSE_WRITE;
        deny = (cause != CAUSE_NONE);
    end
endmodule

// File: rtl/pgw_addr_gen.sv
// Forms the byte address of the entry to fetch at either level.
// Assumes ADDR_W = OFF_W + 2*IDX_W; the slot width follows from the page geometry.
module pgw_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 12
) (
    input  logic                    sel_table,
    input  logic [ADDR_W-OFF_W-1:0] root_ppn,
    input  logic [ADDR_W-OFF_W-1:0] table_ppn,
    input  logic [ADDR_W-1:0]       vaddr,
    output logic [ADDR_W-1:0]       addr
);
    localparam int SLOT_W = OFF_W - IDX_W;

    logic [IDX_W-1:0] dir_idx;
    logic [IDX_W-1:0] tbl_idx;

    // Slice the two index fields and glue them under the chosen page.
    always_comb begin
        dir_idx = vaddr[ADDR_W-1 -: IDX_W];
        tbl_idx = vaddr[OFF_W+IDX_W-1 -: IDX_W];
        if (sel_table)
            addr = {table_ppn, tbl_idx, {SLOT_W{1'b0}}};
        else
            addr = {root_ppn, dir_idx, {SLOT_W{1'b0}}};
    end
endmodule

// File: rtl/pagewalk_unit.sv
// Two-level translation walker: one directory read, then one table read.
// Assumes one walk at a time and at most one outstanding memory read.
// A directory refusal ends the walk without touching the table.
module pagewalk_unit
    import pgw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-OFF_W-1:0] root_ppn,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_vaddr,
    input  logic                    req_write,
    input  logic                    req_user,
    output logic                    mem_req_valid,
    input  logic                    mem_req_ready,
    output logic [ADDR_W-1:0]       mem_req_addr,
    input  logic                    mem_rsp_valid,
    input  logic [ADDR_W-1:0]       mem_rsp_data,
    output logic                    res_valid,
    output logic [ADDR_W-1:0]       res_paddr,
    output logic                    res_fault,
    output logic [1:0]              res_cause,
    output logic                    res_level
);
    localparam int PPN_W = ADDR_W - OFF_W;

    walk_st_e          state;
    logic [ADDR_W-1:0] vaddr_q;
    logic              write_q;
    logic              user_q;
    logic [PPN_W-1:0]  root_q;
    logic [PPN_W-1:0]  tbl_ppn_q;
    logic              deny;
    logic [1:0]        deny_cause;

    pgw_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
        .sel_table (state == ST_TBL_REQ),
        .root_ppn  (root_q),
        .table_ppn (tbl_ppn_q),
        .vaddr     (vaddr_q),
        .addr      (mem_req_addr)
    );

    pgw_entry_check #(.ENTRY_W(ADDR_W)) u_check (
        .entry    (mem_rsp_data),
        .is_write (write_q),
        .is_user  (user_q),
        .deny     (deny),
        .cause    (deny_cause)
    );

    // Handshake outputs follow the state directly.
    always_comb begin
        req_ready     = (state == ST_IDLE);
        mem_req_valid = (state == ST_DIR_REQ) || (state == ST_TBL_REQ);
    end

    // Walk sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            vaddr_q   <= '0;
            write_q   <= 1'b0;
            user_q    <= 1'b0;
            root_q    <= '0;
            tbl_ppn_q <= '0;
            res_valid <= 1'b0;
            res_paddr <= '0;
            res_fault <= 1'b0;
            res_cause <= CAUSE_NONE;
            res_level <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            case (state)
                ST_IDLE: if (req_valid) begin
                    vaddr_q <= req_vaddr;
                    write_q <= req_write;
                    user_q  <= req_user;
                    root_q  <= root_ppn;
                    state   <= ST_DIR_REQ;
                end
                ST_DIR_REQ: if (mem_req_ready) state <= ST_DIR_WAIT;
                ST_DIR_WAIT: if (mem_rsp_valid) begin
                    if (deny) begin
                        res_valid <= 1'b1;
                        res_fault <= 1'b1;
                        res_cause <= deny_cause;
                        res_level <= 1'b0;
                        res_paddr <= '0;
                        state     <= ST_IDLE;
                    end else begin
                        tbl_ppn_q <= mem_rsp_data[ADDR_W-1:OFF_W];
                        state     <= ST_TBL_REQ;
                    end
                end
                ST_TBL_REQ: if (mem_req_ready) state <= ST_TBL_WAIT;
                ST_TBL_WAIT: if (mem_rsp_valid) begin
                    res_valid <= 1'b1;
                    res_fault <= deny;
                    res_cause <= deny_cause;
                    res_level <= 1'b1;
                    res_paddr <= deny ? '0 : {mem_rsp_data[ADDR_W-1:OFF_W], vaddr_q[OFF_W-1:0]};
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // A stalled memory request must not move or vanish.
    assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // A taken request closes the door on the next cycle.
    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // Result strobe lasts one cycle only.
    assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // A granted translation carries no cause code.
    assert_grant_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_fault |-> res_cause == CAUSE_NONE && res_level);

    // Every refusal carries a nonzero cause.
    assert_fault_coded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_fault |-> res_cause != CAUSE_NONE);

    // No memory traffic is asked for while a result is being strobed.
    assert_quiet_on_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !mem_req_valid);
endmodule

// File: tb/pagewalk_unit_test.sv
module pagewalk_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] root_ppn = 20'h00400;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        res_valid;
    logic [31:0] res_paddr;
    logic        res_fault;
    logic [1:0]  res_cause;
    logic        res_level;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] paddr;
        logic        fault;
        logic [1:0]  cause;
        logic        level;
        int          reads;
        logic [31:0] a0;
        logic [31:0] a1;
    } exp_t;

    exp_t        sb_q[$];
    logic [31:0] mem [int unsigned];
    int          rd_cnt = 0;
    logic [31:0] rd_addr [2];

    always #10 clk = ~clk; // 50 MHz

    pagewalk_unit uut (.*);

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // Memory model: random acceptance delay and random response latency.
    initial begin
        bit          pend = 0;
        int          cnt = 0;
        logic [31:0] lat = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mem_req_ready) begin
                mem_req_ready = 1'b0;
                if (rd_cnt < 2) rd_addr[rd_cnt] = lat;
                rd_cnt++;
                pend = 1;
                cnt = $urandom % 3;
            end else if (pend) begin
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rd(lat);
                    pend = 0;
                end else cnt--;
            end else if (mem_req_valid) begin
                lat = mem_req_addr;
                mem_req_ready = ($urandom % 2) == 0;
            end
        end
    end

    // Monitor: pop expected item on each result and compare.
    initial begin
        bit prev = 0;
        forever begin
            @(negedge clk);
            if (prev) check(!res_valid, "R9 strobe width", {31'b0, res_valid}, 32'h0);
            prev = res_valid;
            if (res_valid) begin
                exp_t e;
                if (sb_q.size() == 0) begin
                    check(0, "R9 unexpected result", 32'h1, 32'h0);
                end else begin
                    e = sb_q.pop_front();
                    check(res_fault == e.fault, "R3/R6/R7 fault flag", {31'b0, res_fault}, {31'b0, e.fault});
                    check(res_cause == e.cause, "R8 cause code", {30'b0, res_cause}, {30'b0, e.cause});
                    if (e.fault)
                        check(res_level == e.level, "R5 fault level", {31'b0, res_level}, {31'b0, e.level});
                    else
                        check(res_paddr == e.paddr, "R3 physical address", res_paddr, e.paddr);
                    check(rd_cnt == e.reads, "R4 read count", rd_cnt, e.reads);
                    check(rd_addr[0] == e.a0, "R1 directory address", rd_addr[0], e.a0);
                    if (e.reads == 2)
                        check(rd_addr[1] == e.a1, "R2 table address", rd_addr[1], e.a1);
                end
                rd_cnt = 0;
            end
        end
    end

    // Driver: compute expectation from the stored entries, then issue the request.
    task automatic walk(input logic [31:0] va, input bit wr, input bit usr);
        exp_t        e;
        logic [31:0] pde;
        logic [31:0] pte;
        e.a0   = {root_ppn, va[31:22], 2'b00};
        pde    = rd(e.a0);
        e.a1   = {pde[31:12], va[21:12], 2'b00};
        pte    = rd(e.a1);
        e.paddr = '0;
        e.fault = 1;
        e.reads = 1;
        e.level = 0;
        if (!pde[0])             e.cause = 2'd1;
        else if (usr && !pde[2]) e.cause = 2'd3;
        else if (wr && !pde[1])  e.cause = 2'd2;
        else begin
            e.reads = 2;
            e.level = 1;
            if (!pte[0])             e.cause = 2'd1;
            else if (usr && !pte[2]) e.cause = 2'd3;
            else if (wr && !pte[1])  e.cause = 2'd2;
            else begin
                e.fault = 0;
                e.cause = 2'd0;
                e.paddr = {pte[31:12], va[11:0]};
            end
        end
        sb_q.push_back(e);
        req_vaddr = va;
        req_write = wr;
        req_user  = usr;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_vaddr = 32'hDEAD_BEEF;
        check(!req_ready, "R9 busy after accept", {31'b0, req_ready}, 32'h0);
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    // Watchdog: a hung walk counts as a failure and still reaches the summary.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog expired actual=%0d expected=0", sb_q.size());
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // Sweep tables: directory slot 0x10+p has flags p; table slot 0x20+t has flags t.
        // Bits 11:3 carry junk throughout (R11).
        for (int p = 0; p < 8; p++) begin
            mem[{20'h00400, 10'(16 + p), 2'b00}] = {20'h00500 + 20'(p), 9'h1A8, 3'(p)};
            for (int t = 0; t < 8; t++)
                mem[{20'h00500 + 20'(p), 10'(32 + t), 2'b00}] = {20'h12000 + 20'(p * 8 + t), 9'h0C5, 3'(t)};
        end
        // Alias: two pages map to one frame, one user read-only, one kernel writable.
        mem[{20'h00400, 10'h3F, 2'b00}] = {20'h00600, 12'h007};
        mem[{20'h00600, 10'h001, 2'b00}] = {20'h77777, 12'h005};
        mem[{20'h00600, 10'h002, 2'b00}] = {20'h77777, 12'h003};

        repeat (3) @(negedge clk);
        check(req_ready === 1'b0 || req_ready === 1'b1, "R9 ready known in reset", {31'b0, req_ready}, 32'h1);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready === 1'b1, "R9 idle after reset", {31'b0, req_ready}, 32'h1);
        check(res_valid === 1'b0 && mem_req_valid === 1'b0, "R10 quiet after reset",
              {30'b0, res_valid, mem_req_valid}, 32'h0);

        // Full flag sweep: R4 R5 R6 R7 R8 R11 across every access kind.
        for (int p = 0; p < 8; p++)
            for (int t = 0; t < 8; t++)
                for (int k = 0; k < 4; k++)
                    walk({10'(16 + p), 10'(32 + t), 3'(p), 3'(t), 6'h15}, k[0], k[1]);

        // Alias pair checks (R6, R7).
        walk({10'h3F, 10'h001, 12'hABC}, 1'b0, 1'b1);
        walk({10'h3F, 10'h001, 12'hABC}, 1'b1, 1'b1);
        walk({10'h3F, 10'h002, 12'h123}, 1'b1, 1'b0);
        walk({10'h3F, 10'h002, 12'h123}, 1'b0, 1'b1);
        // Unmapped directory slot reads as zero: absent at level 0 (R4).
        walk({10'h200, 10'h000, 12'h000}, 1'b0, 1'b0);

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule